// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a general-purpose I/O controller for a parameterised number of pins (64 or 96), organised into banks of 32. Software reaches it through a plain 32-bit register port with a byte address, a write strobe and a read-data bus that reflects the addressed word in the same cycle. Each pin has an output-enable bit and an output latch, and software drives the latch through separate write-one-to-set and write-one-to-clear words. The pad inputs pass through a two-stage synchronizer. Software can read back the synchronized level and can have rising and/or falling transitions captured into a sticky status word.

Each function occupies a run of consecutive words, one word per bank. Pin `p` is bit `p % 32` of word `bank = p / 32` within its function's group. A single interrupt line stays high while any captured status bit is set. Software clears status by writing back the mask it read.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: With NB = PINS/32 banks, the word of function f for bank b sits at byte address 4*(f*NB + b). The function codes are: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status. Pin p maps to bit p%32 of bank p/32.
- R2: The level word is read-only. It returns the pad input after two clock edges of synchronization, and writes to it have no effect.
- R3: Direction bits are read/write. A 1 makes pad_oe high for that pin and 0 makes it an input.
- R4: Writing the set word raises the output latch of every pin whose data bit is 1 and leaves the others unchanged. Reading either the set or the clear word returns the output latch, which drives pad_out.
- R5: Writing the clear word lowers the output latch of every pin whose data bit is 1 and leaves the others unchanged.
- R6: When a pin's rising enable is 1, a low-to-high change of its synchronized level sets its status bit. The bit is set at the third rising clock edge after the pad change is first sampled.
- R7: When a pin's falling enable is 1, a high-to-low change sets its status bit. With both enables set, either edge sets it. With neither set, no change of that pin sets it.
- R8: Writing the status word clears exactly the bits written as 1. A set status bit otherwise stays set.
- R9: If an enabled edge and a write-1 clear of the same status bit fall in the same cycle, the bit stays set.
- R10: irq is high exactly while at least one status bit in any bank is set.
- R11: A read returns zero, and a write changes nothing, when the address is not word-aligned or lies beyond the last status word.
- R12: Reset clears direction, output latch, both enables, status, synchronizer stages and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| pad_in | input | PINS | Asynchronous pad input levels |
| pad_out | output | PINS | Output latch driven to the pads |
| pad_oe | output | PINS | Per-pin output enable (direction) |
| irq | output | 1 | Combined edge-status interrupt |

## Verification
The assertions check several behaviours on every cycle. After a set or clear write, the output latch shows the written bits high or low. Direction holds when it is not written. A status bit never drops unless a clear named it, and never rises without an enabled edge. A same-cycle edge wins over its clear, and the interrupt line holds while no clear occurs. Other behaviours only the bench's scenarios can show. These are the address map, the two-edge level latency, the three-edge capture latency, polarity selection under random enable patterns, the effect of writes to the read-only and unmapped addresses, and the exact cycle in which a clear collides with a new edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned LANE_W     = 32;
  localparam int unsigned FEAT_COUNT = 7;

  typedef enum logic [2:0] {
    F_LEVEL = 3'd0,
    F_DIR   = 3'd1,
    F_SET   = 3'd2,
    F_CLR   = 3'd3,
    F_RISE  = 3'd4,
    F_FALL  = 3'd5,
    F_STAT  = 3'd6
  } feat_e;

  // which function group a word index belongs to
  function automatic int unsigned feat_of(input int unsigned word, input int unsigned nbank);
    return word / nbank;
  endfunction

  // which bank inside that group
  function automatic int unsigned bank_of(input int unsigned word, input int unsigned nbank);
    return word % nbank;
  endfunction

  // pure-edge arithmetic shared by every bank
  function automatic logic [LANE_W-1:0] edge_mask(
      input logic [LANE_W-1:0] now_lvl, input logic [LANE_W-1:0] old_lvl,
      input logic [LANE_W-1:0] up_en,   input logic [LANE_W-1:0] dn_en);
    return ((now_lvl & ~old_lvl) & up_en) | ((~now_lvl & old_lvl) & dn_en);
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] level,
  input  logic [LANE_W-1:0] rise_en,
  input  logic [LANE_W-1:0] fall_en,
  input  logic [LANE_W-1:0] clr_mask,
  output logic [LANE_W-1:0] status,
  output logic [LANE_W-1:0] edge_hit
);
  logic [LANE_W-1:0] prev_q;
  logic [LANE_W-1:0] status_q;

  assign edge_hit = edge_mask(level, prev_q, rise_en, fall_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= level;
      status_q <= (status_q & ~clr_mask) | edge_hit;
    end
  end

  assign status = status_q;

  // R8: a set bit only drops when the clear mask named it
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((~status_q & $past(status_q) & ~$past(clr_mask)) == '0));

  // R9: an edge in the same cycle as its clear leaves the bit set
  p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((status_q & $past(edge_hit)) == $past(edge_hit)));

  // R6: a bit is only newly set by an enabled edge
  p_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((status_q & ~$past(status_q) & ~$past(edge_hit)) == '0));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PINS   = 64,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [PINS-1:0]   level,
  input  logic [PINS-1:0]   status,
  output logic [PINS-1:0]   dir_o,
  output logic [PINS-1:0]   out_o,
  output logic [PINS-1:0]   rise_o,
  output logic [PINS-1:0]   fall_o,
  output logic [PINS-1:0]   clr_o
);
  localparam int unsigned NBANK  = PINS / LANE_W;
  localparam int unsigned NWORDS = FEAT_COUNT * NBANK;
  localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word_idx;
  logic              mapped;
  feat_e             feat_i;
  logic [BANK_W-1:0] bank_i;

  assign word_idx = reg_addr[ADDR_W-1:2];
  assign mapped   = (reg_addr[1:0] == 2'b00) && (int'(word_idx) < int'(NWORDS));
  assign feat_i   = feat_e'(feat_of(int'(word_idx), NBANK));
  assign bank_i   = BANK_W'(bank_of(int'(word_idx), NBANK));

  logic [LANE_W-1:0] dir_q  [NBANK];
  logic [LANE_W-1:0] out_q  [NBANK];
  logic [LANE_W-1:0] rise_q [NBANK];
  logic [LANE_W-1:0] fall_q [NBANK];
  logic [LANE_W-1:0] lvl_w  [NBANK];
  logic [LANE_W-1:0] stat_w [NBANK];

  logic [NBANK-1:0] dir_we, set_we, clr_we, rise_we, fall_we, stat_we;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel;
    assign sel        = reg_wr && mapped && (bank_i == BANK_W'(b));
    assign dir_we[b]  = sel && (feat_i == F_DIR);
    assign set_we[b]  = sel && (feat_i == F_SET);
    assign clr_we[b]  = sel && (feat_i == F_CLR);
    assign rise_we[b] = sel && (feat_i == F_RISE);
    assign fall_we[b] = sel && (feat_i == F_FALL);
    assign stat_we[b] = sel && (feat_i == F_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q[b]  <= '0;
        out_q[b]  <= '0;
        rise_q[b] <= '0;
        fall_q[b] <= '0;
      end else begin
        if (dir_we[b])  dir_q[b]  <= reg_wdata;
        if (set_we[b])  out_q[b]  <= out_q[b] | reg_wdata;
        else if (clr_we[b]) out_q[b] <= out_q[b] & ~reg_wdata;
        if (rise_we[b]) rise_q[b] <= reg_wdata;
        if (fall_we[b]) fall_q[b] <= reg_wdata;
      end
    end

    assign lvl_w[b]  = level[b*LANE_W +: LANE_W];
    assign stat_w[b] = status[b*LANE_W +: LANE_W];
    assign dir_o[b*LANE_W +: LANE_W]  = dir_q[b];
    assign out_o[b*LANE_W +: LANE_W]  = out_q[b];
    assign rise_o[b*LANE_W +: LANE_W] = rise_q[b];
    assign fall_o[b*LANE_W +: LANE_W] = fall_q[b];
    assign clr_o[b*LANE_W +: LANE_W]  = stat_we[b] ? reg_wdata : '0;

    // R4: set bits are high in the latch after a set write
    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_we[b] |=> ((out_q[b] & $past(reg_wdata)) == $past(reg_wdata)));

    // R5: cleared bits are low in the latch after a clear write
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we[b] |=> ((out_q[b] & $past(reg_wdata)) == '0));

    // R3: direction only moves on its own write
    p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_we[b] |=> $stable(dir_q[b]));
  end

  always_comb begin
    reg_rdata = '0;
    if (mapped) begin
      unique case (feat_i)
        F_LEVEL:       reg_rdata = lvl_w[bank_i];
        F_DIR:         reg_rdata = dir_q[bank_i];
        F_SET, F_CLR:  reg_rdata = out_q[bank_i];
        F_RISE:        reg_rdata = rise_q[bank_i];
        F_FALL:        reg_rdata = fall_q[bank_i];
        F_STAT:        reg_rdata = stat_w[bank_i];
        default:       reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PINS   = 64,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic              irq
);
  localparam int unsigned NBANK = PINS / LANE_W;

  logic [PINS-1:0] level_s;
  logic [PINS-1:0] status_all;
  logic [PINS-1:0] edge_all;
  logic [PINS-1:0] rise_en, fall_en, clr_mask;

  gpio_sync2 #(.W(PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (level_s)
  );

  gpio_regfile #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .level     (level_s),
    .status    (status_all),
    .dir_o     (pad_oe),
    .out_o     (pad_out),
    .rise_o    (rise_en),
    .fall_o    (fall_en),
    .clr_o     (clr_mask)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_edge
    gpio_edge_bank u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (level_s [b*LANE_W +: LANE_W]),
      .rise_en  (rise_en [b*LANE_W +: LANE_W]),
      .fall_en  (fall_en [b*LANE_W +: LANE_W]),
      .clr_mask (clr_mask[b*LANE_W +: LANE_W]),
      .status   (status_all[b*LANE_W +: LANE_W]),
      .edge_hit (edge_all  [b*LANE_W +: LANE_W])
    );
  end

  assign irq = |status_all;

  // R10: the line holds while nobody clears status
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && (clr_mask == '0)) |=> irq);

  // R10: the line stays low while no enabled edge arrives
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && (edge_all == '0)) |=> !irq);
endmodule

// File: tb/tb_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctrl;
  localparam int PINS = 64;
  localparam int NREG = PINS / 32;
  localparam int AW   = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   reg_addr = '0;
  logic            reg_wr = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [PINS-1:0] pad_in = '0;
  logic [PINS-1:0] pad_out, pad_oe;
  logic            irq;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0]     m_dir[NREG], m_out[NREG], m_rise[NREG], m_fall[NREG], m_stat[NREG];
  logic [PINS-1:0] m_pad;

  always #5 clk = ~clk;

  gpio_bank_ctrl #(.PINS(PINS), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  // address of function code f in bank b (R1)
  function automatic int addr_of(int f, int b);
    return (b + NREG * f) << 2;
  endfunction

  function automatic logic [PINS-1:0] flat(input logic [31:0] w[NREG]);
    logic [PINS-1:0] r = '0;
    for (int b = 0; b < NREG; b++) r[b*32 +: 32] = w[b];
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  // change pads, wait three edges, then fold expected edges into model
  task automatic drive_pads(input logic [PINS-1:0] nv);
    @(negedge clk);
    pad_in = nv;
    repeat (3) @(negedge clk);
    for (int b = 0; b < NREG; b++)
      m_stat[b] |= (m_rise[b] & nv[b*32 +: 32] & ~m_pad[b*32 +: 32]) |
                   (m_fall[b] & ~nv[b*32 +: 32] & m_pad[b*32 +: 32]);
    m_pad = nv;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    logic        any;
    any = 1'b0;
    for (int b = 0; b < NREG; b++) begin
      rd(addr_of(0, b), d); chk({tag, " R2 level"}, 64'(d), 64'(m_pad[b*32 +: 32]));
      rd(addr_of(1, b), d); chk({tag, " R3 dir"},   64'(d), 64'(m_dir[b]));
      rd(addr_of(2, b), d); chk({tag, " R4 out"},   64'(d), 64'(m_out[b]));
      rd(addr_of(3, b), d); chk({tag, " R5 out"},   64'(d), 64'(m_out[b]));
      rd(addr_of(4, b), d); chk({tag, " R1 rise"},  64'(d), 64'(m_rise[b]));
      rd(addr_of(5, b), d); chk({tag, " R1 fall"},  64'(d), 64'(m_fall[b]));
      rd(addr_of(6, b), d); chk({tag, " R6 stat"},  64'(d), 64'(m_stat[b]));
      any |= (m_stat[b] != 0);
    end
    chk({tag, " R3 pad_oe"},  64'(pad_oe),  64'(flat(m_dir)));
    chk({tag, " R4 pad_out"}, 64'(pad_out), 64'(flat(m_out)));
    chk({tag, " R10 irq"},    64'(irq),     64'(any));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd7321));
    for (int b = 0; b < NREG; b++) begin
      m_dir[b] = 0; m_out[b] = 0; m_rise[b] = 0; m_fall[b] = 0; m_stat[b] = 0;
    end
    m_pad = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check_all("R12 reset");

    // R2: level words ignore writes; pads high in both banks
    drive_pads({32'hA5A5_0F0F, 32'h1234_8001});
    wr(addr_of(0, 0), 32'hFFFF_FFFF);
    check_all("R2 ro");

    // R11: unaligned and out-of-range accesses
    rd(addr_of(7, 0), d); chk("R11 read past end", 64'(d), 64'h0);
    rd(addr_of(1, 0) + 1, d); chk("R11 unaligned read", 64'(d), 64'h0);
    wr(addr_of(7, 0), 32'hFFFF_FFFF);
    wr(addr_of(2, 0) + 2, 32'hFFFF_FFFF);
    check_all("R11 write ignored");

    // R7: toggle with no enables leaves status clear
    drive_pads(~m_pad);
    check_all("R7 none");

    // R6/R7/R9 directed on bank 0 bit 5
    wr(addr_of(4, 0), 32'h20); m_rise[0] = 32'h20;
    wr(addr_of(5, 0), 32'h20); m_fall[0] = 32'h20;
    drive_pads(m_pad & ~64'h20);
    drive_pads(m_pad | 64'h20);
    rd(addr_of(6, 0), d); chk("R6 rise capture", 64'(d), 64'h20);
    // collision: fall edge reaches status on the same edge as the clear
    @(negedge clk); pad_in = m_pad & ~64'h20;
    @(negedge clk);
    @(negedge clk); reg_addr = AW'(addr_of(6, 0)); reg_wdata = 32'h20; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    m_pad = pad_in;
    rd(addr_of(6, 0), d); chk("R9 edge beats clear", 64'(d), 64'h20);
    chk("R10 irq held", 64'(irq), 64'h1);
    wr(addr_of(6, 0), 32'h20); m_stat[0] = 0;
    check_all("R8 cleared");

    // R6: capture timing, not visible after two edges, visible after three
    @(negedge clk); pad_in = m_pad | 64'h20;
    @(negedge clk); @(negedge clk);
    chk("R6 not yet", 64'(irq), 64'h0);
    @(negedge clk);
    chk("R6 third edge", 64'(irq), 64'h1);
    m_pad = pad_in; m_stat[0] = 32'h20;
    wr(addr_of(6, 0), 32'h20); m_stat[0] = 0;

    // random register and pad traffic
    for (int it = 0; it < 60; it++) begin
      int op, bk;
      logic [31:0] v;
      op = $urandom_range(0, 5);
      bk = $urandom_range(0, NREG - 1);
      v  = $urandom;
      case (op)
        0: begin wr(addr_of(1, bk), v); m_dir[bk] = v; end
        1: begin wr(addr_of(2, bk), v); m_out[bk] |= v; end
        2: begin wr(addr_of(3, bk), v); m_out[bk] &= ~v; end
        3: begin wr(addr_of(4, bk), v); m_rise[bk] = v; end
        4: begin wr(addr_of(5, bk), v); m_fall[bk] = v; end
        default: begin wr(addr_of(6, bk), v); m_stat[bk] &= ~v; end
      endcase
      if ((it % 3) == 0) drive_pads({$urandom, $urandom});
      check_all("rand R4 R5 R7 R8");
    end

    // R8: write back what was read clears everything
    for (int b = 0; b < NREG; b++) begin
      rd(addr_of(6, b), d);
      wr(addr_of(6, b), d);
      m_stat[b] = 0;
    end
    check_all("R8 writeback");
    finish_run();
  end
endmodule